// File: doc/BRIEF.md
# Symmetric Scaling Filter Coefficient Store

This block keeps the coefficient set of a 32-tap symmetric scaling filter in an 11-word packed image and lets a filter datapath fetch any single tap. Each stored word carries three signed 9-bit coefficients. A kernel is loaded as a serial stream of its 16 distinct coefficients. The block places each one at its forward position and, in the same cycle, at its mirrored position. Because of that, the second half of the image never needs a separate copy pass.

Two read paths share the image. The tap port turns a tap number from 0 to 31 into a word and lane. It returns the sign-extended coefficient on the next clock. The word port returns a whole packed word, in the layout a word-oriented consumer expects, on the next clock.

Top module: `kernel_store`

## Requirements
- R1: After synchronous reset every tap reads 0, every word reads 0 and `load_done` is low.
- R2: For words 0 to 4, coefficient 3w+j of the kernel sits in bits [9j+8:9j] of word w (j = 0, 1, 2), and bits [31:27] of every word are zero.
- R3: Word 5 holds coefficient 15 in both bits [8:0] and bits [17:9], and its bits [31:18] are zero.
- R4: Word i, for i from 6 to 10, always equals word 10−i.
- R5: A tap index t from 0 to 15 returns coefficient t, sign-extended.
- R6: A tap index t from 16 to 31 returns coefficient 31−t, so that tap t and tap 31−t always match.
- R7: `tap_coef` reflects the `tap_idx` sampled at the previous rising edge. `word_data` reflects the `word_idx` sampled at the previous rising edge.
- R8: A loaded value keeps only its low 9 bits, read as a two's-complement number in −256..255.
- R9: Coefficients are taken in index order, one per cycle in which `load_valid` is high. Cycles with `load_valid` low are skipped. `load_done` is high for exactly the one cycle after the edge that accepts the 16th coefficient.
- R10: Word indices 11 to 15 read as zero.
- R11: A further load replaces every coefficient of the previous kernel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | A coefficient is presented this cycle |
| load_coef | input | IN_W | Signed coefficient; only the low 9 bits are kept |
| load_done | output | 1 | One-cycle pulse after the last coefficient of a kernel is written |
| tap_idx | input | 5 | Tap number 0..31 |
| tap_coef | output | 9 | Signed coefficient of the tap, one cycle after the index |
| word_idx | input | 4 | Packed word number |
| word_data | output | 32 | Packed word, one cycle after the index |

## Verification
The hardest case to reach from the ports is a load whose accepted coefficients are separated by idle cycles. In that case the lane and word counters must hold across the gaps, and the pad slot must stay clear. The stimulus therefore reloads the kernel twice with an idle cycle after every coefficient. Both reloads use values chosen to differ in every slot from the kernel before them, so a stale or misplaced lane shows up on a word read. One of them also carries out-of-range values whose low 9 bits differ in sign from the original, which exercises truncation. After each load, all 32 taps are read in back-to-back cycles, so a wrong read latency cannot hide behind a repeated index.

// File: rtl/kstore_pkg.sv
package kstore_pkg;

    localparam int COEF_W      = 9;
    localparam int TAPS        = 32;
    localparam int PER_WORD    = 3;
    localparam int WORD_W      = 32;
    localparam int UNIQUE      = TAPS / 2;
    localparam int HALF_WORDS  = (UNIQUE + PER_WORD - 1) / PER_WORD;
    localparam int TOTAL_WORDS = 2 * HALF_WORDS - 1;
    localparam int TAP_W       = $clog2(TAPS);
    localparam int WADDR_W     = $clog2(TOTAL_WORDS);
    localparam int LANE_W      = $clog2(PER_WORD);
    localparam int USED_W      = PER_WORD * COEF_W;

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic [WORD_W-1:0]        word_t;

    typedef struct packed {
        logic [WADDR_W-1:0] word;
        logic [LANE_W-1:0]  lane;
    } slot_t;

    typedef struct packed {
        logic                en;
        logic [WADDR_W-1:0]  word;
        logic [PER_WORD-1:0] lane_mask;
        coef_t               val;
    } wr_t;

    // Tap to storage slot: the lower half (plus the duplicated centre tap)
    // runs forward; the upper half counts down from the last word.
    function automatic slot_t tap_slot(input logic [TAP_W-1:0] tap);
        int    t;
        int    k;
        slot_t s;
        t = int'(tap);
        if (t <= UNIQUE) begin
            s.word = WADDR_W'(t / PER_WORD);
            s.lane = LANE_W'(t % PER_WORD);
        end else begin
            k      = TAPS - 1 - t;
            s.word = WADDR_W'(TOTAL_WORDS - 1 - k / PER_WORD);
            s.lane = LANE_W'(k % PER_WORD);
        end
        return s;
    endfunction

    function automatic logic [WADDR_W-1:0] mirror_of(input logic [WADDR_W-1:0] w);
        return WADDR_W'(TOTAL_WORDS - 1) - w;
    endfunction

    function automatic coef_t lane_get(input word_t w, input logic [LANE_W-1:0] lane);
        coef_t r;
        r = '0;
        for (int j = 0; j < PER_WORD; j++) begin
            if (LANE_W'(j) == lane) r = w[j*COEF_W +: COEF_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/kstore_loader.sv
module kstore_loader
    import kstore_pkg::*;
#(
    parameter int IN_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_valid,
    input  logic [IN_W-1:0] load_coef,
    output wr_t             wr,
    output logic            done
);

    localparam logic [WADDR_W-1:0] LAST_WORD = WADDR_W'(HALF_WORDS - 1);
    localparam logic [LANE_W-1:0]  LAST_LANE = LANE_W'((UNIQUE - 1) % PER_WORD);
    localparam logic [LANE_W-1:0]  TOP_LANE  = LANE_W'(PER_WORD - 1);

    logic [WADDR_W-1:0] word_q;
    logic [LANE_W-1:0]  lane_q;
    logic               last;

    assign last = (word_q == LAST_WORD) && (lane_q == LAST_LANE);

    always_comb begin
        wr.en        = load_valid;
        wr.word      = word_q;
        wr.val       = coef_t'(load_coef[COEF_W-1:0]);
        wr.lane_mask = '0;
        for (int j = 0; j < PER_WORD; j++) begin
            if (LANE_W'(j) == lane_q) wr.lane_mask[j] = 1'b1;
            // centre coefficient also fills the following slot
            if (last && (LANE_W'(j) == lane_q + 1'b1)) wr.lane_mask[j] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            lane_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= load_valid && last;
            if (load_valid) begin
                if (last) begin
                    word_q <= '0;
                    lane_q <= '0;
                end else if (lane_q == TOP_LANE) begin
                    word_q <= word_q + 1'b1;
                    lane_q <= '0;
                end else begin
                    lane_q <= lane_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/kstore_bank.sv
module kstore_bank
    import kstore_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  wr_t                                wr,
    input  logic [WADDR_W-1:0]                 rd_word,
    output word_t                              rd_data,
    input  slot_t                              tap_at,
    output coef_t                              tap_val,
    output logic [TOTAL_WORDS-1:0][WORD_W-1:0] image
);

    localparam logic [WADDR_W-1:0] MIRROR_LIMIT = WADDR_W'(HALF_WORDS - 1);
    localparam logic [WADDR_W-1:0] WORD_COUNT   = WADDR_W'(TOTAL_WORDS);

    logic [TOTAL_WORDS-1:0][WORD_W-1:0] image_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            image_q <= '0;
        end else if (wr.en) begin
            for (int j = 0; j < PER_WORD; j++) begin
                if (wr.lane_mask[j]) begin
                    image_q[wr.word][j*COEF_W +: COEF_W] <= wr.val;
                    if (wr.word < MIRROR_LIMIT)
                        image_q[mirror_of(wr.word)][j*COEF_W +: COEF_W] <= wr.val;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= (rd_word < WORD_COUNT) ? image_q[rd_word] : '0;
    end

    assign tap_val = lane_get(image_q[tap_at.word], tap_at.lane);
    assign image   = image_q;

endmodule

// File: rtl/kstore_tap_port.sv
module kstore_tap_port
    import kstore_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [TAP_W-1:0] tap_idx,
    output slot_t            slot,
    input  coef_t            lane_val,
    output coef_t            tap_coef
);

    assign slot = tap_slot(tap_idx);

    always_ff @(posedge clk) begin
        if (rst) tap_coef <= '0;
        else     tap_coef <= lane_val;
    end

endmodule

// File: rtl/kernel_store.sv
module kernel_store
    import kstore_pkg::*;
#(
    parameter int IN_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_valid,
    input  logic [IN_W-1:0]          load_coef,
    output logic                     load_done,
    input  logic [TAP_W-1:0]         tap_idx,
    output logic signed [COEF_W-1:0] tap_coef,
    input  logic [WADDR_W-1:0]       word_idx,
    output logic [WORD_W-1:0]        word_data
);

    wr_t                                wr;
    slot_t                              slot;
    coef_t                              lane_val;
    coef_t                              tap_q;
    logic [TOTAL_WORDS-1:0][WORD_W-1:0] image;

    kstore_loader #(.IN_W(IN_W)) u_loader (
        .clk        (clk),
        .rst        (rst),
        .load_valid (load_valid),
        .load_coef  (load_coef),
        .wr         (wr),
        .done       (load_done)
    );

    kstore_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_word (word_idx),
        .rd_data (word_data),
        .tap_at  (slot),
        .tap_val (lane_val),
        .image   (image)
    );

    kstore_tap_port u_tap (
        .clk      (clk),
        .rst      (rst),
        .tap_idx  (tap_idx),
        .slot     (slot),
        .lane_val (lane_val),
        .tap_coef (tap_q)
    );

    assign tap_coef = tap_q;

endmodule

// File: rtl/kernel_store_chk.sv
module kernel_store_chk
    import kstore_pkg::*;
(
    input logic                               clk,
    input logic                               rst,
    input logic                               load_valid,
    input logic                               load_done,
    input logic [WADDR_W-1:0]                 word_idx,
    input logic [WORD_W-1:0]                  word_data,
    input logic [TOTAL_WORDS-1:0][WORD_W-1:0] image
);

    localparam int MID = HALF_WORDS - 1;

    for (genvar i = 0; i < MID; i++) begin : g_mirror
        a_r4_mirror_match: assert property (@(posedge clk) disable iff (rst)
            image[i] == image[TOTAL_WORDS-1-i]);
    end

    for (genvar i = 0; i < TOTAL_WORDS; i++) begin : g_top
        a_r2_unused_bits_zero: assert property (@(posedge clk) disable iff (rst)
            image[i][WORD_W-1:USED_W] == '0);
    end

    a_r3_centre_pad_zero: assert property (@(posedge clk) disable iff (rst)
        image[MID][WORD_W-1:2*COEF_W] == '0);

    a_r3_centre_pair_equal: assert property (@(posedge clk) disable iff (rst)
        image[MID][COEF_W-1:0] == image[MID][2*COEF_W-1:COEF_W]);

    a_r9_done_needs_valid: assert property (@(posedge clk) disable iff (rst)
        load_done |-> $past(load_valid));

    a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
        load_done |=> !load_done);

    a_r10_range_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (word_idx >= WADDR_W'(TOTAL_WORDS)) |=> (word_data == '0));

endmodule

bind kernel_store kernel_store_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_valid (load_valid),
    .load_done  (load_done),
    .word_idx   (word_idx),
    .word_data  (word_data),
    .image      (image)
);

// File: tb/kernel_store_bench.sv
module kernel_store_bench;

    typedef struct {
        int    kind;   // 0 tap, 1 word, 2 done
        int    idx;
        longint expv;
        string req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_valid = 1'b0;
    logic [11:0] load_coef = '0;
    logic        load_done;
    logic [4:0]  tap_idx = '0;
    logic signed [8:0] tap_coef;
    logic [3:0]  word_idx = '0;
    logic [31:0] word_data;

    int    checks = 0;
    int    errors = 0;
    bit    all_done = 1'b0;
    int    refc [16];
    item_t sb [$];

    always #5 clk = ~clk;

    kernel_store #(.IN_W(12)) u_kernel_store (
        .clk        (clk),
        .rst        (rst),
        .load_valid (load_valid),
        .load_coef  (load_coef),
        .load_done  (load_done),
        .tap_idx    (tap_idx),
        .tap_coef   (tap_coef),
        .word_idx   (word_idx),
        .word_data  (word_data)
    );

    function automatic int trunc9(input int v);
        return ((v & 511) ^ 256) - 256;
    endfunction

    function automatic int exp_tap(input int t);
        return (t < 16) ? refc[t] : refc[31 - t];
    endfunction

    function automatic longint exp_word(input int w);
        int     base;
        int     slot;
        int     v;
        longint r;
        r = 0;
        if (w >= 11) return 0;
        base = (w >= 6) ? 10 - w : w;
        for (int j = 0; j < 3; j++) begin
            slot = 3 * base + j;
            v = (slot < 16) ? refc[slot] : ((slot == 16) ? refc[15] : 0);
            r = r | (longint'(v & 511) << (9 * j));
        end
        return r;
    endfunction

    task automatic rd_tap(input int t, input string r);
        @(negedge clk);
        tap_idx = 5'(t);
        sb.push_back('{0, t, longint'(exp_tap(t)), r});
    endtask

    task automatic rd_word(input int w, input string r);
        @(negedge clk);
        word_idx = 4'(w);
        sb.push_back('{1, w, exp_word(w), r});
    endtask

    task automatic load_kernel(input int vals [16], input int gap);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            load_valid = 1'b1;
            load_coef  = 12'(vals[k]);
            sb.push_back('{2, k, (k == 15) ? 1 : 0, "R9"});
            if (gap != 0) begin
                @(negedge clk);
                load_valid = 1'b0;
                load_coef  = 12'hA5A;
                sb.push_back('{2, k, 0, "R9"});
            end
        end
        @(negedge clk);
        load_valid = 1'b0;
        sb.push_back('{2, 16, 0, "R9"});
        for (int k = 0; k < 16; k++) refc[k] = trunc9(vals[k]);
    endtask

    task automatic sweep(input string lo, input string hi, input string wr_req);
        for (int t = 0; t < 32; t++) rd_tap(t, (t < 16) ? lo : hi);
        for (int w = 0; w < 11; w++) rd_word(w, wr_req);
    endtask

    // monitor: items pushed before an edge are compared just after it
    initial begin
        item_t it;
        longint act;
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                it = sb.pop_front();
                case (it.kind)
                    0:       act = longint'(tap_coef);
                    1:       act = longint'(word_data);
                    default: act = longint'(load_done);
                endcase
                checks++;
                if (act != it.expv) begin
                    errors++;
                    $display("FAIL %s: kind %0d index %0d actual %0d expected %0d",
                             it.req, it.kind, it.idx, act, it.expv);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!all_done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p1 [16];
        int p2 [16];
        int p3 [16];
        p1 = '{5, -1, 12, -40, 77, -128, 255, -256, 3, 0, -9, 100, -200, 64, -3, 150};
        p2 = '{300, -300, 511, -257, 256, 1000, -1000, 2047,
               -2048, 1, -1, 0, 700, -700, 258, -513};
        p3 = '{-7, 44, -90, 18, 6, -250, 131, 99, -64, 37, -2, 240, -15, 8, 171, -33};
        for (int k = 0; k < 16; k++) refc[k] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset contents
        sb.push_back('{2, 0, 0, "R1"});
        rd_tap(0, "R1");
        rd_tap(31, "R1");
        rd_tap(16, "R1");
        rd_word(5, "R1");
        rd_word(10, "R1");

        // first kernel, back-to-back coefficients
        load_kernel(p1, 0);
        sweep("R5", "R6", "R2 R3 R4");
        for (int w = 11; w < 16; w++) rd_word(w, "R10");

        // R7: alternating indices every cycle
        rd_tap(3, "R7");
        rd_tap(28, "R7");
        rd_tap(15, "R7");
        rd_tap(16, "R7");
        rd_word(0, "R7");
        rd_word(10, "R7");
        rd_word(5, "R7");

        // out-of-range values with idle cycles between them
        load_kernel(p2, 1);
        sweep("R8", "R8", "R8");

        // reload: every slot changes
        load_kernel(p3, 1);
        sweep("R11", "R11", "R11");
        rd_word(7, "R4");
        rd_word(5, "R3");

        @(negedge clk);
        @(negedge clk);
        all_done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule